// File: doc/BRIEF.md
# Dual-Source Low-Frequency Clock Controller

This block manages two 32 kHz clock sources for an always-on domain: an on-die free-running oscillator and a crystal oscillator that can also be placed in bypass, where an external 32 kHz clock is passed straight through. Software configures the block through a single-cycle synchronous write port and a registered read port. It sets the oscillator enables, the crystal mode and the free-running trim. It picks which source feeds the domain, and it opens or closes the selected clock towards five consumer outputs.

A select request is accepted only when the requested source is usable. A refused request leaves the selection as it was and raises a sticky flag. After an accepted change, the new source is reported as active only once the change has passed a two-stage synchronizer. Until then the current-source readback reads "none". Five control registers each carry a lock bit. Once set, the lock stays set until the power-on reset input is asserted. A trim change made while the free-running oscillator runs is sequenced: the oscillator is switched off, the trim is loaded, and then the oscillator is switched back on.

Register map (16-bit data, 3-bit address): 0 free-running control, 1 free-running trim, 2 crystal control, 3 monitor control, 4 gate/select control, 5 mask set, 6 mask clear, 7 status (read only). The lock bit of registers 0 to 4 is bit 15.

Top module: `lfclk_ctrl`

## Requirements
- R1: After reset, fro_en_o, xo_mode_o, fro_trim_o, trim_autoload_dis_o, mon_cfg_o and clk_out_o are all zero. Reads of the gate/select register (address 4) and of status (address 7) return 0.
- R2: Writing address 0 sets the free-running enable from bit 0. fro_en_o follows on the next cycle, and status bit 8 (state bit 0) reports this enable.
- R3: Writing address 2 sets the crystal mode from bits 1:0 (0 off, 1 on, 3 bypass). Writing the reserved value 2 leaves the mode unchanged. Status bit 9 (state bit 1) is 1 whenever the mode is not 0.
- R4: While the free-running enable is 0, writing address 1 loads the trim from bits 10:0 and the autoload-disable bit from bit 12. Both show on their outputs on the next cycle.
- R5: While the free-running enable is 1, a trim write drops fro_en_o for exactly two cycles. fro_trim_o changes in the second of those cycles, and fro_en_o returns in the third. Trim writes that arrive during this sequence are ignored.
- R6: A write to address 4 requests a source through bit 0 (0 free-running, 1 crystal). A change to crystal is accepted only while xo_rdy_i is 1. A change to free-running is accepted only while the free-running enable is 1. A refused change keeps the old selection and sets the sticky flag at status bit 4. A request for the source already selected is never refused.
- R7: After an accepted change of selection, status bits 2:1 and the current-source field (status bits 13:12) read 0 for two cycles. After that they report the new source.
- R8: Once settled, free-running active (status bit 2, current source 1) requires the free-running source to be selected and fro_en_o to be 1. Crystal active (status bit 1, current source 2) requires the crystal source to be selected and the mode to be non-zero.
- R9: A write to address 4 loads the 5-bit output mask from bits 12:8. A write to address 5 ORs bits 4:0 into the mask, and a write to address 6 clears the mask bits that are 1 in bits 4:0. Addresses 5 and 6 read back the mask in bits 4:0.
- R10: clk_out_o[i] equals mask bit i ANDed with the clock of the active source. With no source active, clk_out_o is 0.
- R11: Writing 1 to bit 15 of addresses 0 to 4 locks that register. Later writes to a locked register leave it unchanged, and writes to addresses 5 and 6 are ignored while address 4 is locked. Writing 0 to a lock bit does not clear it. Only rst_n clears the locks.
- R12: rd_data is registered. It shows the register selected by rd_addr one cycle after the address is presented.
- R13: Writing address 3 drives mon_cfg_o from bits 4:0. Status bit 3 reports mon_err_i, and status bit 0 reports xo_rdy_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |
| xo_rdy_i | input | 1 | Crystal oscillator stable |
| mon_err_i | input | 1 | Clock monitor error |
| clk32_fro_i | input | 1 | Free-running oscillator clock |
| clk32_xo_i | input | 1 | Crystal or bypass clock |
| fro_en_o | output | 1 | Free-running oscillator enable |
| fro_trim_o | output | 11 | Free-running trim code |
| trim_autoload_dis_o | output | 1 | Blocks boot-time trim loading |
| xo_mode_o | output | 2 | Crystal mode |
| mon_cfg_o | output | 5 | Clock monitor configuration |
| clk_out_o | output | 5 | Gated 32 kHz clocks to consumers |

## Verification
Every register write is sampled on one rising edge, and its effect on the outputs is checked at the falling edge that follows. Read data is checked one full cycle after the address is driven. A selection change is read back three times in a row, and the bench expects "none", "none", then the new source. The trim sequence is checked at three consecutive falling edges. The gated clocks are combinational, so they are checked a fraction of a cycle after the bench toggles the source clocks, well before the next rising edge.

// File: rtl/lfclk_pkg.sv
package lfclk_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 3;
  localparam int unsigned NLOCK = 5;
  localparam int unsigned LOCK_BIT = 15;
  localparam int unsigned AUTOLD_BIT = 12;
  localparam int unsigned MASK_LSB = 8;
  localparam int unsigned STATE_LSB = 8;
  localparam int unsigned SRC_LSB = 12;

  typedef enum logic [AW-1:0] {
    A_FCTL  = 3'd0,
    A_FTRIM = 3'd1,
    A_XCTL  = 3'd2,
    A_MCTL  = 3'd3,
    A_GCTL  = 3'd4,
    A_GSET  = 3'd5,
    A_GCLR  = 3'd6,
    A_STAT  = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    XO_OFF  = 2'd0,
    XO_ON   = 2'd1,
    XO_RSVD = 2'd2,
    XO_BYP  = 2'd3
  } xo_mode_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FRO  = 2'd1,
    SRC_XO   = 2'd2
  } cur_src_e;

  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_HOLD = 2'd1,
    TS_LOAD = 2'd2
  } trim_st_e;
endpackage

// File: rtl/lfclk_regs.sv
module lfclk_regs import lfclk_pkg::*; #(
  parameter int unsigned N_OUT = 5,
  parameter int unsigned MON_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [NLOCK-1:0] lock_q,
  output logic [NLOCK-1:0] wr_ok,
  output logic             fro_en_q,
  output logic [1:0]       xo_mode_q,
  output logic [MON_W-1:0] mon_cfg_q,
  output logic [N_OUT-1:0] mask_q,
  output logic             autoload_dis_q
);
  logic [NLOCK-1:0] hit;
  logic [NLOCK-1:0] lock_d;
  logic             set_ok, clr_ok;
  logic             fro_en_d;
  logic [1:0]       xo_mode_d;
  logic [MON_W-1:0] mon_cfg_d;
  logic [N_OUT-1:0] mask_d;
  logic             autoload_dis_d;
  logic             unused_data;

  assign unused_data = ^{wr_data[14:13], wr_data[7:5]};

  for (genvar i = 0; i < NLOCK; i++) begin : g_lock
    assign hit[i]    = wr_en && (wr_addr == AW'(i));
    assign wr_ok[i]  = hit[i] && !lock_q[i];
    assign lock_d[i] = lock_q[i] | (wr_ok[i] & wr_data[LOCK_BIT]);
  end

  assign set_ok = wr_en && (wr_addr == A_GSET) && !lock_q[A_GCTL];
  assign clr_ok = wr_en && (wr_addr == A_GCLR) && !lock_q[A_GCTL];

  always_comb begin
    fro_en_d       = fro_en_q;
    xo_mode_d      = xo_mode_q;
    mon_cfg_d      = mon_cfg_q;
    mask_d         = mask_q;
    autoload_dis_d = autoload_dis_q;
    if (wr_ok[A_FCTL])  fro_en_d = wr_data[0];
    if (wr_ok[A_FTRIM]) autoload_dis_d = wr_data[AUTOLD_BIT];
    if (wr_ok[A_XCTL] && (wr_data[1:0] != XO_RSVD)) xo_mode_d = wr_data[1:0];
    if (wr_ok[A_MCTL])  mon_cfg_d = wr_data[MON_W-1:0];
    if (wr_ok[A_GCTL])  mask_d = wr_data[MASK_LSB +: N_OUT];
    else if (set_ok)    mask_d = mask_q | wr_data[N_OUT-1:0];
    else if (clr_ok)    mask_d = mask_q & ~wr_data[N_OUT-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q         <= '0;
      fro_en_q       <= 1'b0;
      xo_mode_q      <= XO_OFF;
      mon_cfg_q      <= '0;
      mask_q         <= '0;
      autoload_dis_q <= 1'b0;
    end else begin
      lock_q         <= lock_d;
      fro_en_q       <= fro_en_d;
      xo_mode_q      <= xo_mode_d;
      mon_cfg_q      <= mon_cfg_d;
      mask_q         <= mask_d;
      autoload_dis_q <= autoload_dis_d;
    end
  end
endmodule

// File: rtl/lfclk_trim_seq.sv
module lfclk_trim_seq import lfclk_pkg::*; #(
  parameter int unsigned TRIM_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trim_wr,
  input  logic [TRIM_W-1:0] trim_in,
  input  logic              fro_en_q,
  output logic [TRIM_W-1:0] trim_q,
  output logic              busy
);
  trim_st_e          st_q, st_d;
  logic [TRIM_W-1:0] trim_d;
  logic [TRIM_W-1:0] pend_q;
  logic              pend_ce;

  always_comb begin
    st_d    = st_q;
    trim_d  = trim_q;
    pend_ce = 1'b0;
    unique case (st_q)
      TS_IDLE: begin
        if (trim_wr) begin
          if (fro_en_q) begin
            st_d    = TS_HOLD;
            pend_ce = 1'b1;
          end else begin
            trim_d = trim_in;
          end
        end
      end
      TS_HOLD: begin
        trim_d = pend_q;
        st_d   = TS_LOAD;
      end
      TS_LOAD: st_d = TS_IDLE;
      default: st_d = TS_IDLE;
    endcase
  end

  assign busy = (st_q != TS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TS_IDLE;
      trim_q <= '0;
      pend_q <= '0;
    end else begin
      st_q   <= st_d;
      trim_q <= trim_d;
      if (pend_ce) pend_q <= trim_in;
    end
  end
endmodule

// File: rtl/lfclk_src_sel.sv
module lfclk_src_sel #(
  parameter int unsigned SYNC_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_wr,
  input  logic sel_req,
  input  logic fro_en_q,
  input  logic xo_rdy_i,
  input  logic xo_on,
  input  logic fro_run,
  output logic sel_q,
  output logic bad_sel_q,
  output logic fro_act,
  output logic xo_act
);
  logic                sel_d, bad_sel_d;
  logic [SYNC_STG-1:0] stg_q, stg_d;
  logic                settled;

  always_comb begin
    sel_d     = sel_q;
    bad_sel_d = bad_sel_q;
    if (sel_wr && (sel_req != sel_q)) begin
      if (sel_req ? xo_rdy_i : fro_en_q) sel_d = sel_req;
      else                               bad_sel_d = 1'b1;
    end
  end

  assign stg_d[0] = sel_q;
  for (genvar i = 1; i < SYNC_STG; i++) begin : g_stg
    assign stg_d[i] = stg_q[i-1];
  end

  assign settled = (stg_q == {SYNC_STG{sel_q}});
  assign fro_act = settled & ~sel_q & fro_run;
  assign xo_act  = settled &  sel_q & xo_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      bad_sel_q <= 1'b0;
      stg_q     <= '0;
    end else begin
      sel_q     <= sel_d;
      bad_sel_q <= bad_sel_d;
      stg_q     <= stg_d;
    end
  end
endmodule

// File: rtl/lfclk_gate.sv
module lfclk_gate #(
  parameter int unsigned N_OUT = 5
) (
  input  logic             fro_act,
  input  logic             xo_act,
  input  logic             clk32_fro_i,
  input  logic             clk32_xo_i,
  input  logic [N_OUT-1:0] mask_q,
  output logic [N_OUT-1:0] clk_out_o
);
  logic src_clk;

  assign src_clk = (fro_act & clk32_fro_i) | (xo_act & clk32_xo_i);

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign clk_out_o[i] = mask_q[i] & src_clk;
  end
endmodule

// File: rtl/lfclk_ctrl.sv
module lfclk_ctrl import lfclk_pkg::*; #(
  parameter int unsigned N_OUT    = 5,
  parameter int unsigned TRIM_W   = 11,
  parameter int unsigned MON_W    = 5,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              xo_rdy_i,
  input  logic              mon_err_i,
  input  logic              clk32_fro_i,
  input  logic              clk32_xo_i,
  output logic              fro_en_o,
  output logic [TRIM_W-1:0] fro_trim_o,
  output logic              trim_autoload_dis_o,
  output logic [1:0]        xo_mode_o,
  output logic [MON_W-1:0]  mon_cfg_o,
  output logic [N_OUT-1:0]  clk_out_o
);
  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic [NLOCK-1:0] lock_q;
  logic [NLOCK-1:0] wr_ok;
  logic             fro_en_q;
  logic [1:0]       xo_mode_q;
  logic [N_OUT-1:0] mask_q;
  logic             trim_busy;
  logic             sel_q, bad_sel_q;
  logic             fro_act, xo_act;
  logic             xo_on;
  logic [1:0]       cur_src;
  logic [DW-1:0]    rd_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  lfclk_regs #(.N_OUT(N_OUT), .MON_W(MON_W)) regs_i (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lock_q(lock_q), .wr_ok(wr_ok),
    .fro_en_q(fro_en_q), .xo_mode_q(xo_mode_q), .mon_cfg_q(mon_cfg_o),
    .mask_q(mask_q), .autoload_dis_q(trim_autoload_dis_o)
  );

  lfclk_trim_seq #(.TRIM_W(TRIM_W)) trim_i (
    .clk(clk), .rst_n(rst_sync_n),
    .trim_wr(wr_ok[A_FTRIM]), .trim_in(wr_data[TRIM_W-1:0]),
    .fro_en_q(fro_en_q), .trim_q(fro_trim_o), .busy(trim_busy)
  );

  assign fro_en_o  = fro_en_q & ~trim_busy;
  assign xo_mode_o = xo_mode_q;
  assign xo_on     = (xo_mode_q != XO_OFF);

  lfclk_src_sel #(.SYNC_STG(SYNC_STG)) sel_i (
    .clk(clk), .rst_n(rst_sync_n),
    .sel_wr(wr_ok[A_GCTL]), .sel_req(wr_data[0]),
    .fro_en_q(fro_en_q), .xo_rdy_i(xo_rdy_i), .xo_on(xo_on), .fro_run(fro_en_o),
    .sel_q(sel_q), .bad_sel_q(bad_sel_q), .fro_act(fro_act), .xo_act(xo_act)
  );

  lfclk_gate #(.N_OUT(N_OUT)) gate_i (
    .fro_act(fro_act), .xo_act(xo_act),
    .clk32_fro_i(clk32_fro_i), .clk32_xo_i(clk32_xo_i),
    .mask_q(mask_q), .clk_out_o(clk_out_o)
  );

  assign cur_src = fro_act ? SRC_FRO : (xo_act ? SRC_XO : SRC_NONE);

  always_comb begin
    rd_next = '0;
    case (reg_addr_e'(rd_addr))
      A_FCTL: begin
        rd_next[0]        = fro_en_q;
        rd_next[LOCK_BIT] = lock_q[A_FCTL];
      end
      A_FTRIM: begin
        rd_next[TRIM_W-1:0] = fro_trim_o;
        rd_next[AUTOLD_BIT] = trim_autoload_dis_o;
        rd_next[LOCK_BIT]   = lock_q[A_FTRIM];
      end
      A_XCTL: begin
        rd_next[1:0]      = xo_mode_q;
        rd_next[LOCK_BIT] = lock_q[A_XCTL];
      end
      A_MCTL: begin
        rd_next[MON_W-1:0] = mon_cfg_o;
        rd_next[LOCK_BIT]  = lock_q[A_MCTL];
      end
      A_GCTL: begin
        rd_next[0]                 = sel_q;
        rd_next[MASK_LSB +: N_OUT] = mask_q;
        rd_next[LOCK_BIT]          = lock_q[A_GCTL];
      end
      A_GSET, A_GCLR: rd_next[N_OUT-1:0] = mask_q;
      A_STAT: begin
        rd_next[0]                = xo_rdy_i;
        rd_next[1]                = xo_act;
        rd_next[2]                = fro_act;
        rd_next[3]                = mon_err_i;
        rd_next[4]                = bad_sel_q;
        rd_next[STATE_LSB +: 2]   = {xo_on, fro_en_q};
        rd_next[SRC_LSB +: 2]     = cur_src;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_data <= '0;
    else             rd_data <= rd_next;
  end
endmodule

// File: rtl/lfclk_ctrl_chk.sv
module lfclk_ctrl_chk #(
  parameter int unsigned N_OUT  = 5,
  parameter int unsigned TRIM_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fro_en_o,
  input logic              fro_en_q,
  input logic [TRIM_W-1:0] fro_trim_o,
  input logic              sel_q,
  input logic              bad_sel_q,
  input logic              xo_rdy_i,
  input logic              fro_act,
  input logic              xo_act,
  input logic [1:0]        cur_src,
  input logic [4:0]        lock_q,
  input logic [N_OUT-1:0]  clk_out_o
);
  a_r5_trim_moves_while_off: assert property (@(posedge clk) disable iff (!rst_n)
    (fro_trim_o != $past(fro_trim_o)) |-> !fro_en_o);

  a_r6_xo_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !$past(sel_q)) |-> $past(xo_rdy_i));

  a_r6_fro_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q && $past(sel_q)) |-> $past(fro_en_q));

  a_r6_bad_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bad_sel_q |=> bad_sel_q);

  a_r7_switch_reads_none: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> (cur_src == 2'd0));

  a_r10_no_source_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (!fro_act && !xo_act) |-> (clk_out_o == '0));

  a_r11_fctl_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[0] |=> $stable(fro_en_q));

  a_r11_locks_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != 5'd0) |=> ((lock_q & $past(lock_q)) == $past(lock_q)));
endmodule

bind lfclk_ctrl lfclk_ctrl_chk #(.N_OUT(N_OUT), .TRIM_W(TRIM_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n),
  .fro_en_o(fro_en_o), .fro_en_q(fro_en_q), .fro_trim_o(fro_trim_o),
  .sel_q(sel_q), .bad_sel_q(bad_sel_q), .xo_rdy_i(xo_rdy_i),
  .fro_act(fro_act), .xo_act(xo_act), .cur_src(cur_src),
  .lock_q(lock_q), .clk_out_o(clk_out_o)
);

// File: tb/lfclk_ctrl_tb.sv
`timescale 1ns/100ps
module lfclk_ctrl_tb_top;
  import lfclk_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic        xo_rdy, mon_err, cf, cx;
  logic        fro_en_o, trim_ald_o;
  logic [10:0] trim_o;
  logic [1:0]  mode_o;
  logic [4:0]  mon_o, clk_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lfclk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .xo_rdy_i(xo_rdy), .mon_err_i(mon_err),
    .clk32_fro_i(cf), .clk32_xo_i(cx), .fro_en_o(fro_en_o), .fro_trim_o(trim_o),
    .trim_autoload_dis_o(trim_ald_o), .xo_mode_o(mode_o), .mon_cfg_o(mon_o),
    .clk_out_o(clk_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] stat_exp(input logic xr, input logic xa, input logic fa,
      input logic me, input logic bad, input logic [1:0] st, input logic [1:0] src);
    return {2'b00, src, 2'b00, st, 3'b000, bad, me, fa, xa, xr};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic m_sel, m_bad, m_fe;
    logic [1:0] m_mode;
    logic fa, xa;
    xo_rdy = 0; mon_err = 0; cf = 0; cx = 0;
    do_reset();

    // R1 reset state
    chk("R1 fro_en", fro_en_o, 0);
    chk("R1 mode", mode_o, 0);
    chk("R1 trim", {trim_ald_o, trim_o}, 0);
    chk("R1 mon", mon_o, 0);
    chk("R1 clk_out", clk_out, 0);
    rd(A_GCTL, v); chk("R1 gctl", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);

    // R2 enable
    wr(A_FCTL, 16'h0001); chk("R2 fro_en_o", fro_en_o, 1);
    rd(A_STAT, v); chk("R2 state bit0", v[8], 1);
    wr(A_FCTL, 16'h0000); chk("R2 fro_en_o off", fro_en_o, 0);

    // R6 refused change to free-running while it is disabled
    wr(A_XCTL, 16'h0001); xo_rdy = 1;
    wr(A_GCTL, 16'h0001); repeat (3) @(negedge clk);
    wr(A_GCTL, 16'h0000); repeat (3) @(negedge clk);
    rd(A_GCTL, v); chk("R6 sel kept when fro off", v[0], 1);
    rd(A_STAT, v); chk("R6 bad flag fro rule", v[4], 1);
    do_reset();

    // R6 R8 sweep of enable, ready and request
    m_sel = 0; m_bad = 0;
    wr(A_XCTL, 16'h0001);
    for (int xr = 0; xr < 2; xr++) begin
      for (int fe = 0; fe < 2; fe++) begin
        for (int rs = 0; rs < 2; rs++) begin
          xo_rdy = xr[0];
          wr(A_FCTL, {15'd0, fe[0]});
          wr(A_GCTL, {15'd0, rs[0]});
          if (rs[0] != m_sel) begin
            if (rs[0] ? xr[0] : fe[0]) m_sel = rs[0];
            else m_bad = 1;
          end
          repeat (3) @(negedge clk);
          rd(A_GCTL, v); chk("R6 sel", v[0], m_sel);
          fa = !m_sel && fe[0];
          xa = m_sel;
          rd(A_STAT, v);
          chk("R8 status", v, stat_exp(xr[0], xa, fa, 0, m_bad, {1'b1, fe[0]},
              fa ? 2'd1 : (xa ? 2'd2 : 2'd0)));
        end
      end
    end

    // R7 switch timing: now sel=1, fro on, xo ready
    wr(A_GCTL, 16'h0000);
    rd(A_STAT, v); chk("R7 none 1st", {v[13:12], v[2:1]}, 0);
    rd(A_STAT, v); chk("R7 none 2nd", {v[13:12], v[2:1]}, 0);
    rd(A_STAT, v); chk("R7 fro after", {v[13:12], v[2:1]}, {2'd1, 2'b10});
    wr(A_GCTL, 16'h0001);
    rd(A_STAT, v); chk("R7 none 1st b", v[13:12], 0);
    rd(A_STAT, v); chk("R7 none 2nd b", v[13:12], 0);
    rd(A_STAT, v); chk("R7 xo after", {v[13:12], v[2:1]}, {2'd2, 2'b01});

    // R3 mode sweep
    m_mode = 2'd1;
    for (int m = 0; m < 4; m++) begin
      wr(A_XCTL, {14'd0, m[1:0]});
      if (m != 2) m_mode = m[1:0];
      chk("R3 mode out", mode_o, m_mode);
      rd(A_XCTL, v); chk("R3 mode read", v, {14'd0, m_mode});
      rd(A_STAT, v); chk("R3 state bit1", v[9], m_mode != 0);
    end

    // R9 R10 mask sweep on free-running source
    wr(A_GCTL, 16'h0000); repeat (3) @(negedge clk);
    for (int m = 0; m < 32; m++) begin
      wr(A_GCTL, {3'd0, m[4:0], 8'd0});
      cf = 1; cx = 0; #0.4;
      chk("R10 gated high", clk_out, m[4:0]);
      cf = 0; cx = 1; #0.4;
      chk("R10 gated low", clk_out, 0);
    end
    @(negedge clk);
    wr(A_GCTL, 16'h0500);
    wr(A_GSET, 16'h0012);
    rd(A_GSET, v); chk("R9 set", v, 16'h0017);
    wr(A_GCLR, 16'h0006);
    rd(A_GCLR, v); chk("R9 clear", v, 16'h0011);
    wr(A_FCTL, 16'h0000);
    cf = 1; cx = 1; #0.4;
    chk("R10 fro disabled no clock", clk_out, 0);
    @(negedge clk);
    wr(A_GCTL, 16'h1101); repeat (3) @(negedge clk);
    cf = 0; cx = 1; #0.4;
    chk("R10 xo clock", clk_out, 5'h11);
    cx = 0; @(negedge clk);

    // R4 trim with oscillator off
    wr(A_FTRIM, 16'h15A3);
    chk("R4 trim", trim_o, 11'h5A3);
    chk("R4 autoload", trim_ald_o, 1);
    rd(A_FTRIM, v); chk("R4 trim read", v, 16'h15A3);
    wr(A_FTRIM, 16'h07FF); chk("R4 trim max", {trim_ald_o, trim_o}, 12'h7FF);
    wr(A_FTRIM, 16'h0000); chk("R4 trim zero", {trim_ald_o, trim_o}, 0);

    // R5 trim with oscillator running
    wr(A_FCTL, 16'h0001);
    wr_en = 1; wr_addr = A_FTRIM; wr_data = 16'h0123;
    @(negedge clk); wr_en = 0;
    chk("R5 off 1st", {fro_en_o, trim_o}, {1'b0, 11'h000});
    @(negedge clk);
    chk("R5 off 2nd loaded", {fro_en_o, trim_o}, {1'b0, 11'h123});
    @(negedge clk);
    chk("R5 back on", {fro_en_o, trim_o}, {1'b1, 11'h123});
    wr_en = 1; wr_addr = A_FTRIM; wr_data = 16'h02AA;
    @(negedge clk); wr_data = 16'h00F0;
    @(negedge clk); wr_en = 0;
    @(negedge clk);
    chk("R5 write during sequence ignored", {fro_en_o, trim_o}, {1'b1, 11'h2AA});

    // R13 monitor
    wr(A_MCTL, 16'h0015); chk("R13 mon cfg", mon_o, 5'h15);
    mon_err = 1;
    rd(A_STAT, v); chk("R13 mon err", v[3], 1);
    mon_err = 0;

    // R12 read latency
    rd(A_FCTL, v); chk("R12 fctl", v, 16'h0001);
    rd_addr = A_MCTL; #0.4;
    chk("R12 no early data", rd_data, 16'h0001);
    @(negedge clk); chk("R12 data next cycle", rd_data, 16'h0015);

    // R11 locks
    wr(A_FCTL, 16'h8000);
    wr(A_FTRIM, 16'h80AB);
    wr(A_XCTL, 16'h8001);
    wr(A_MCTL, 16'h800A);
    wr(A_GCTL, 16'h8301);
    wr(A_FCTL, 16'h0001); chk("R11 fctl locked", fro_en_o, 0);
    wr(A_FTRIM, 16'h07FF); chk("R11 trim locked", trim_o, 11'h0AB);
    wr(A_XCTL, 16'h0003); chk("R11 xctl locked", mode_o, 1);
    wr(A_MCTL, 16'h001F); chk("R11 mctl locked", mon_o, 5'h0A);
    wr(A_GCTL, 16'h1F00);
    wr(A_GSET, 16'h001F);
    wr(A_GCLR, 16'h0003);
    rd(A_GCTL, v); chk("R11 gctl locked", v, 16'h8301);
    rd(A_FCTL, v); chk("R11 lock not cleared by 0", v, 16'h8000);
    do_reset();
    rd(A_FCTL, v); chk("R11 reset clears lock", v, 0);
    wr(A_FCTL, 16'h0001); chk("R11 write after reset", fro_en_o, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule